// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a processor subsystem. A binary counter advances on every system clock while the watchdog runs. If software does not restart it in time, the counter overflows. The block then fires a one-cycle interrupt and raises a level output that can be wired to the reset inputs of other devices. Software restarts the counter by writing a fixed key byte to a command register. The timeout is chosen from four lengths through a field in a mode register.

The watchdog runs from the moment reset ends. Stopping it is guarded: software must first clear the enable bit in the mode register and then write a second, separate key to the command register. A single stray write cannot silence it. A low-power state input freezes the counter in the deep sleep states and lets it count in the light one.

Both registers sit behind one write port. `wr_addr` selects the register: 0 for the mode register and 1 for the command register.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the watchdog is running with period setting 00 and both outputs are low. The first interrupt follows 2^BASE_EXP counting clocks after reset is released.
- R2: Writing 0x4E to the command register clears the counter at that clock edge and drops `wd_out`. The next interrupt comes one full period after the write.
- R3: Mode register bits 6:5 select the period. The settings 00, 01, 10 and 11 give 2^BASE_EXP, 2^(BASE_EXP+2), 2^(BASE_EXP+4) and 2^(BASE_EXP+6) clocks.
- R4: On overflow, `wd_irq` is high for exactly one cycle. `wd_out` rises with it and stays high until a clear key or reset. The counter wraps and raises the interrupt again after another full period.
- R5: Writing mode bit 7 as 0 and then writing 0xB1 to the command register stops the counter. No interrupt occurs while it is stopped.
- R6: Writing mode bit 7 as 0 without 0xB1 leaves the watchdog counting. Writing 0xB1 while bit 7 is 1 has no effect.
- R7: Writing mode bit 7 as 1 restarts a stopped watchdog at once, from the count it held when it stopped.
- R8: Command writes other than 0x4E and 0xB1 do not change the counter or the outputs.
- R9: A mode write that changes bits 6:5 clears the counter. A mode write that keeps the same period does not.
- R10: `pwr_mode` 00 (run) and 01 (light idle) let the counter advance. 10 (deep idle) and 11 (stop) freeze it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | Register select: 0 = mode, 1 = command |
| wr_data | input | 8 | Write data byte |
| pwr_mode | input | 2 | Power state: 00 run, 01 light idle, 10 deep idle, 11 stop |
| wd_irq | output | 1 | One-cycle overflow interrupt |
| wd_out | output | 1 | Held overflow level for external reset use |

## Verification
The bench builds the block with BASE_EXP = 4, so the four periods are 16, 64, 256 and 1024 clocks. At that size, every period setting can be measured to the exact cycle, as can wrap-around, a frozen interval in each sleep state, and a restart from a held count. Against the default exponent of 15, the same timing rules would need millions of cycles.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the keyed watchdog.
// Assumes an 8-bit register write bus and a 2-bit power state code.
package wdog_pkg;
    localparam logic [7:0] KEY_CLEAR = 8'h4E;
    localparam logic [7:0] KEY_HALT  = 8'hB1;
    localparam logic       SEL_MODE  = 1'b0;
    localparam logic       SEL_CMD   = 1'b1;
    localparam int         NUM_PER   = 4;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_LIDLE = 2'b01,
        PWR_DIDLE = 2'b10,
        PWR_STOP  = 2'b11
    } pwr_e;
endpackage

// File: rtl/wdog_ctrl.sv
// Module: register decode and run/stop state for the watchdog.
// Holds the enable bit and the period field. Decodes the two command keys
// and applies the guarded two-step stop. Assumes one write per strobe cycle.
module wdog_ctrl
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic       running,
    output logic [1:0] per_sel,
    output logic       cnt_clr,
    output logic       key_clr
);
    logic       en_bit;
    logic       wr_mode;
    logic       wr_cmd;
    logic       halt_ok;

    // Decode which register is written and whether a key matches.
    always_comb begin
        wr_mode = wr_en && (wr_addr == SEL_MODE);
        wr_cmd  = wr_en && (wr_addr == SEL_CMD);
        key_clr = wr_cmd && (wr_data == KEY_CLEAR);
        halt_ok = wr_cmd && (wr_data == KEY_HALT) && !en_bit;
        cnt_clr = key_clr || (wr_mode && (wr_data[6:5] != per_sel));
    end

    // Mode register fields and the run/stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bit  <= 1'b1;
            per_sel <= 2'b00;
            running <= 1'b1;
        end else begin
            if (wr_mode) begin
                en_bit  <= wr_data[7];
                per_sel <= wr_data[6:5];
                if (wr_data[7]) running <= 1'b1;
            end else if (halt_ok) begin
                running <= 1'b0;
            end
        end
    end

    AST_STOP_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(wr_cmd && wr_data == KEY_HALT && !en_bit)); // R5
    AST_HALT_IGNORED_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && en_bit && running) |=> running); // R6
    AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && wr_data[7]) |=> running); // R7
endmodule

// File: rtl/wdog_count.sv
// Module: period counter for the watchdog.
// Advances only while the watchdog is running and the power state allows it.
// Flags the overflow when the count passes the selected terminal value.
// Assumes a clear request takes priority over both counting and overflow.
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 15,
    parameter int EXP_STEP = 2,
    localparam int CNT_W   = BASE_EXP + EXP_STEP * (NUM_PER - 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    input  logic [1:0] pwr_mode,
    input  logic [1:0] per_sel,
    input  logic       cnt_clr,
    output logic       ovf
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term_tab [NUM_PER];
    logic [CNT_W-1:0] term;
    logic             advance;
    pwr_e             pwr;

    // One terminal value per period setting, computed from the exponents.
    for (genvar g = 0; g < NUM_PER; g++) begin : g_term
        localparam logic [CNT_W:0] LEN = (CNT_W+1)'(1) << (BASE_EXP + EXP_STEP * g);
        assign term_tab[g] = CNT_W'(LEN - (CNT_W+1)'(1));
    end

    // Pick the terminal value and decide whether this cycle counts.
    always_comb begin
        pwr     = pwr_e'(pwr_mode);
        term    = term_tab[per_sel];
        advance = running && (pwr == PWR_RUN || pwr == PWR_LIDLE);
        ovf     = advance && (cnt == term) && !cnt_clr;
    end

    // Count up, wrap at the terminal value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (cnt_clr)  cnt <= '0;
        else if (advance)  cnt <= (cnt == term) ? '0 : cnt + 1'b1;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0)); // R2
    AST_FROZEN_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && (pwr_mode[1] || !running)) |=> $stable(cnt)); // R10
    AST_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (cnt <= $past(term))); // R3
endmodule

// File: rtl/wdog_alarm.sv
// Module: interrupt pulse and held output for the watchdog.
// Turns the overflow flag into a one-cycle interrupt and a level output.
// The level output is released only by the clear key.
module wdog_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic key_clr,
    output logic wd_irq,
    output logic wd_out
);
    // Register the pulse and hold the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_irq <= 1'b0;
            wd_out <= 1'b0;
        end else begin
            wd_irq <= ovf;
            if (key_clr)  wd_out <= 1'b0;
            else if (ovf) wd_out <= 1'b1;
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |=> !wd_irq); // R4
    AST_OUT_RISES_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_out) |-> wd_irq); // R4
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_out && !key_clr) |=> wd_out); // R4
    AST_KEY_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        key_clr |=> !wd_out); // R2
endmodule

// File: rtl/wdog_keyed.sv
// Module: top of the keyed watchdog timer.
// Connects the register/key logic, the period counter and the alarm stage.
// Assumes the write bus is synchronous to clk and that reset is synchronous.
module wdog_keyed #(
    parameter int BASE_EXP = 15,
    parameter int EXP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] pwr_mode,
    output logic       wd_irq,
    output logic       wd_out
);
    logic       running;
    logic [1:0] per_sel;
    logic       cnt_clr;
    logic       key_clr;
    logic       ovf;

    wdog_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .running (running),
        .per_sel (per_sel),
        .cnt_clr (cnt_clr),
        .key_clr (key_clr)
    );

    wdog_count #(
        .BASE_EXP (BASE_EXP),
        .EXP_STEP (EXP_STEP)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .pwr_mode (pwr_mode),
        .per_sel  (per_sel),
        .cnt_clr  (cnt_clr),
        .ovf      (ovf)
    );

    wdog_alarm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .key_clr (key_clr),
        .wd_irq  (wd_irq),
        .wd_out  (wd_out)
    );

    AST_IRQ_ONLY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> $past(running)); // R5
endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
    localparam int BEXP = 4;
    localparam int L0   = 1 << BEXP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] pwr_mode = 2'b00;
    logic       wd_irq;
    logic       wd_out;
    int         checks = 0;
    int         errors = 0;
    int         n;

    always #10 clk = ~clk;

    wdog_keyed #(.BASE_EXP(BEXP), .EXP_STEP(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwr_mode(pwr_mode), .wd_irq(wd_irq), .wd_out(wd_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One register write; starts and ends at a falling edge.
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Count falling edges until the interrupt is seen; limit+1 if it never comes.
    task automatic wait_irq(input int limit, output int cnt);
        cnt = 0;
        for (int i = 0; i <= limit; i++) begin
            @(negedge clk);
            cnt++;
            if (wd_irq) break;
        end
    endtask

    task automatic t_reset;
        idle(3);
        check("R1 irq in reset", int'(wd_irq), 0);
        check("R1 out in reset", int'(wd_out), 0);
        rst_n = 1'b1;
        wait_irq(2000, n);
        check("R1 first timeout", n, L0);
        check("R4 out raised", int'(wd_out), 1);
        idle(1);
        check("R4 irq one cycle", int'(wd_irq), 0);
        check("R4 out held", int'(wd_out), 1);
        wait_irq(2000, n);
        check("R4 wrap period", n, L0 - 1);
    endtask

    task automatic t_clear;
        wr(1'b1, 8'h4E);
        check("R2 out dropped", int'(wd_out), 0);
        wait_irq(2000, n);
        check("R2 period after clear", n, L0);
    endtask

    task automatic t_bad_codes;
        wr(1'b1, 8'h4E);
        idle(5);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hFF);
        wr(1'b1, 8'h4F);
        wait_irq(2000, n);
        check("R8 stray codes ignored", n, L0 - 8);
    endtask

    task automatic t_half_disable;
        wr(1'b1, 8'h4E);
        wr(1'b0, 8'h00);
        wait_irq(2000, n);
        check("R6 enable bit alone", n, L0 - 1);
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h4E);
        wr(1'b1, 8'hB1);
        wait_irq(2000, n);
        check("R6 halt key while enabled", n, L0 - 1);
    endtask

    task automatic t_disable;
        wr(1'b1, 8'h4E);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hB1);
        wait_irq(100, n);
        check("R5 stopped no irq", n, 101);
        check("R5 out unchanged while stopped", int'(wd_out), 0);
        wr(1'b0, 8'h80);
        wait_irq(2000, n);
        check("R7 resume from held count", n, L0 - 2);
    endtask

    task automatic t_power;
        wr(1'b1, 8'h4E);
        pwr_mode = 2'b10;
        wait_irq(20, n);
        check("R10 deep idle frozen", n, 21);
        pwr_mode = 2'b11;
        wait_irq(20, n);
        check("R10 stop frozen", n, 21);
        pwr_mode = 2'b01;
        idle(4);
        pwr_mode = 2'b00;
        wait_irq(2000, n);
        check("R10 light idle counts", n, L0 - 4);
    endtask

    task automatic t_period_change;
        wr(1'b1, 8'h4E);
        idle(6);
        wr(1'b0, 8'hA0);
        wait_irq(2000, n);
        check("R9 change clears", n, L0 * 4);
        wr(1'b1, 8'h4E);
        idle(10);
        wr(1'b0, 8'hA0);
        wait_irq(2000, n);
        check("R9 same period keeps count", n, L0 * 4 - 11);
        wr(1'b0, 8'h80);
    endtask

    task automatic t_periods;
        for (int s = 0; s < 4; s++) begin
            wr(1'b0, {1'b1, 2'(s), 5'b0});
            wr(1'b1, 8'h4E);
            wait_irq(5000, n);
            check($sformatf("R3 period sel %0d", s), n, L0 << (2 * s));
        end
    endtask

    initial begin
        idle(1);
        t_reset();
        t_clear();
        t_bad_codes();
        t_half_disable();
        t_disable();
        t_power();
        t_period_change();
        t_periods();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule